// File: doc/BRIEF.md
# Up-Counting Compare-Period Timer

This block is a 16-bit timer that counts upward from zero on every clock while it is enabled. The period comes from a compare register (compare A). When the count completes one period, the timer gives a one-cycle period pulse and starts again from zero. A second compare register (compare B) sets a point inside the period where a separate one-cycle match pulse appears.

Software reaches the block through a single-cycle, byte-addressed register access port. Each access is either one byte or two bytes wide. The mode word is split over two byte addresses. The high byte holds the enable and load controls, and each byte has its own reserved bits. The two compare-mode bytes are plain storage that reads back. An access that breaks the rules changes nothing and raises a one-cycle error flag. Such an access can be a reserved bit set, enable and load set together, a wrong width, a write to the counter, or an unmapped address.

Top module: `tmr_upcount`

## Requirements
- R1: After reset every register reads zero, the counter reads zero, and the period pulse, match pulse and error flag are low.
- R2: The mode low byte is at address 0x84 and the mode high byte is at 0x85. A two-byte access at 0x84 carries the low byte in data bits 7:0 and the high byte in bits 15:8, and a read returns the same layout. A one-byte access at 0x85 uses data bits 7:0.
- R3: A write that sets any of bits 5, 3 or 2 of the mode low byte, or bits 2:0 of the mode high byte, is discarded and raises the error flag.
- R4: A mode-high write with both bit 7 (enable) and bit 6 (load) set is discarded and raises the error flag.
- R5: A legal write of the mode high byte with bit 7 set starts counting from zero, taking the current compare A value as the period. If compare A is zero at that moment, the counter does not run.
- R6: With period P, the counter reads k mod P after the k-th clock since the start. The period pulse is high for exactly the cycles where k is a positive multiple of P.
- R7: A write to compare A while the counter runs does not change the running period until the next start.
- R8: The match pulse is high for one cycle each time counting brings the count to the compare B value (address 0xD4). It never fires when compare B is not below the period.
- R9: The counter at 0xA4 reads the running count, or zero while stopped. A one-byte read returns the low eight bits, zero-extended.
- R10: A legal mode-high write with bit 7 clear stops the counter. After it the counter reads zero and both pulse outputs stay low.
- R11: Compare A (0xC4) and compare B (0xD4) accept one- or two-byte writes, and a one-byte write zero-extends data bits 7:0. The compare-mode bytes at 0xB4 and 0xB5 accept one-byte access only and read back what was written.
- R12: An illegal access changes no state. This covers a write to 0xA4, a two-byte access at 0xB4, 0xB5 or 0x85, and any access to an unmapped address. The error flag is high in the cycle after the access, and a read in these cases returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on each rising edge while running |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_vld | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 8 | Byte address |
| acc_wide | input | 1 | 1 for a two-byte access, 0 for one byte |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for the addressed register (combinational, regardless of acc_vld) |
| acc_err | output | 1 | One-cycle flag after an illegal access |
| period_pulse | output | 1 | One-cycle pulse at each completed period |
| match_b_pulse | output | 1 | One-cycle pulse when the count reaches compare B |

## Verification
The period pulse and the match pulse fall in the same cycle when compare B is zero. In that case the wrap back to zero is also the compare B match, and with a period of one both pulses fire on every clock. The stimulus table contains a vector with compare B at zero and a vector with period one. For every clock after the start, the bench predicts each pulse on its own from k mod P, so a design that lets one event mask the other misses a predicted pulse. A further case writes compare A in the middle of a run, to check that the latched period is kept.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_W = 16;
  localparam int BUS_AW = 8;

  localparam logic [7:0] A_MODE_LO = 8'h84;
  localparam logic [7:0] A_MODE_HI = 8'h85;
  localparam logic [7:0] A_COUNT   = 8'hA4;
  localparam logic [7:0] A_CMODE_A = 8'hB4;
  localparam logic [7:0] A_CMODE_B = 8'hB5;
  localparam logic [7:0] A_CMP_A   = 8'hC4;
  localparam logic [7:0] A_CMP_B   = 8'hD4;

  localparam logic [7:0] LO_RSVD = 8'h2C;
  localparam logic [7:0] HI_RSVD = 8'h07;
  localparam int HI_EN = 7;
  localparam int HI_LD = 6;

  function automatic logic lo_legal(logic [7:0] b);
    return (b & LO_RSVD) == 8'h00;
  endfunction

  function automatic logic hi_legal(logic [7:0] b);
    return ((b & HI_RSVD) == 8'h00) && !(b[HI_EN] && b[HI_LD]);
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int W  = tmr_pkg::TMR_W,
  parameter int AW = tmr_pkg::BUS_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_vld,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_wide,
  input  logic [W-1:0]  acc_wdata,
  input  logic [W-1:0]  cnt_view,
  output logic [W-1:0]  cmp_a,
  output logic [W-1:0]  cmp_b,
  output logic          hi_load,
  output logic          hi_en,
  output logic [W-1:0]  acc_rdata,
  output logic          acc_err
);
  import tmr_pkg::*;

  localparam int NCMP = 2;
  localparam int NCM  = 2;
  localparam logic [NCMP-1:0][7:0] CMP_ADR = {A_CMP_B, A_CMP_A};
  localparam logic [NCM-1:0][7:0]  CM_ADR  = {A_CMODE_B, A_CMODE_A};

  logic [NCMP-1:0]        sel_cmp;
  logic [NCM-1:0]         sel_cm;
  logic                   sel_lo, sel_hi, sel_cnt;
  logic [NCMP-1:0][W-1:0] cmp_q;
  logic [NCM-1:0][7:0]    cm_q;
  logic [7:0]             mode_lo_q, mode_hi_q;
  logic                   err_q;
  logic                   wr_ok, rd_ok, acc_ok, wr_go;
  logic [7:0]             wd_lo, wd_hi, hi_val;
  logic [W-1:0]           full;

  assign wd_lo   = acc_wdata[7:0];
  assign wd_hi   = acc_wdata[15:8];
  assign sel_lo  = acc_addr == AW'(A_MODE_LO);
  assign sel_hi  = acc_addr == AW'(A_MODE_HI);
  assign sel_cnt = acc_addr == AW'(A_COUNT);

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp_sel
    assign sel_cmp[g] = acc_addr == AW'(CMP_ADR[g]);
  end
  for (genvar g = 0; g < NCM; g++) begin : g_cm_sel
    assign sel_cm[g] = acc_addr == AW'(CM_ADR[g]);
  end

  // legality of the current access, by register and width
  always_comb begin
    wr_ok = 1'b0;
    rd_ok = 1'b0;
    if (sel_lo) begin
      rd_ok = 1'b1;
      wr_ok = lo_legal(wd_lo) && (!acc_wide || hi_legal(wd_hi));
    end else if (sel_hi) begin
      rd_ok = !acc_wide;
      wr_ok = !acc_wide && hi_legal(wd_lo);
    end else if (sel_cnt) begin
      rd_ok = 1'b1;
    end else if (|sel_cm) begin
      rd_ok = !acc_wide;
      wr_ok = !acc_wide;
    end else if (|sel_cmp) begin
      rd_ok = 1'b1;
      wr_ok = 1'b1;
    end
  end

  assign acc_ok  = acc_wr ? wr_ok : rd_ok;
  assign wr_go   = acc_vld && acc_wr && wr_ok;
  assign hi_load = wr_go && (sel_hi || (sel_lo && acc_wide));
  assign hi_val  = sel_hi ? wd_lo : wd_hi;
  assign hi_en   = hi_val[HI_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lo_q <= '0;
      mode_hi_q <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= acc_vld && !acc_ok;
      if (wr_go && sel_lo) mode_lo_q <= wd_lo;
      if (hi_load)         mode_hi_q <= hi_val;
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cmp_q[g] <= '0;
      else if (wr_go && sel_cmp[g]) cmp_q[g] <= acc_wide ? acc_wdata : W'(wd_lo);
    end
  end

  for (genvar g = 0; g < NCM; g++) begin : g_cm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cm_q[g] <= '0;
      else if (wr_go && sel_cm[g]) cm_q[g] <= wd_lo;
    end
  end

  assign cmp_a   = cmp_q[0];
  assign cmp_b   = cmp_q[1];
  assign acc_err = err_q;

  always_comb begin
    full = '0;
    if (sel_lo)  full = W'({mode_hi_q, mode_lo_q});
    if (sel_hi)  full = W'(mode_hi_q);
    if (sel_cnt) full = cnt_view;
    for (int g = 0; g < NCM; g++)  if (sel_cm[g])  full = W'(cm_q[g]);
    for (int g = 0; g < NCMP; g++) if (sel_cmp[g]) full = cmp_q[g];
  end

  assign acc_rdata = !rd_ok ? '0 : (acc_wide ? full : W'(full[7:0]));

  assert_reject_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_ok) |=> (acc_err && $stable(cmp_q) && $stable(mode_hi_q)));
  assert_no_spurious_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_vld || acc_ok) |=> !acc_err);
  assert_lo_rsvd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lo_q & LO_RSVD) == 8'h00);
  assert_hi_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_hi_q & HI_RSVD) == 8'h00) && !(mode_hi_q[HI_EN] && mode_hi_q[HI_LD]));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = tmr_pkg::TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hi_load,
  input  logic         hi_en,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] cnt_view,
  output logic         period_pulse,
  output logic         match_b_pulse
);
  function automatic logic at_end(logic [W-1:0] c, logic [W-1:0] p);
    return c == (p - W'(1));
  endfunction

  function automatic logic [W-1:0] next_cnt(logic [W-1:0] c, logic [W-1:0] p);
    return at_end(c, p) ? '0 : c + W'(1);
  endfunction

  logic [W-1:0] cnt_q, per_q, cnt_nx;
  logic         run_q, ovf_q, mb_q, go, wrap_now;

  assign go       = hi_en && (cmp_a != '0);
  assign wrap_now = run_q && at_end(cnt_q, per_q);
  assign cnt_nx   = next_cnt(cnt_q, per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      per_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      mb_q  <= 1'b0;
    end else if (hi_load) begin
      run_q <= go;
      per_q <= cmp_a;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      mb_q  <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_nx;
      ovf_q <= wrap_now;
      mb_q  <= cnt_nx == cmp_b;
    end else begin
      ovf_q <= 1'b0;
      mb_q  <= 1'b0;
    end
  end

  assign cnt_view      = run_q ? cnt_q : '0;
  assign period_pulse  = ovf_q;
  assign match_b_pulse = mb_q;

  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_load && hi_en && cmp_a != '0) |=> (run_q && cnt_q == '0 && per_q == $past(cmp_a)));
  assert_zero_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_load && cmp_a == '0) |=> !run_q);
  assert_below_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q));
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (run_q && cnt_q == '0));
  assert_period_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !hi_load) |=> $stable(per_q));
  assert_match_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mb_q |-> (cnt_q == $past(cmp_b)));
  assert_quiet_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!ovf_q && !mb_q && cnt_view == '0));
  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_load && !hi_en) |=> !run_q);
endmodule

// File: rtl/tmr_upcount.sv
module tmr_upcount #(
  parameter int W  = tmr_pkg::TMR_W,
  parameter int AW = tmr_pkg::BUS_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_vld,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_wide,
  input  logic [W-1:0]  acc_wdata,
  output logic [W-1:0]  acc_rdata,
  output logic          acc_err,
  output logic          period_pulse,
  output logic          match_b_pulse
);
  logic [W-1:0] cmp_a, cmp_b, cnt_view;
  logic         hi_load, hi_en;

  tmr_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wide(acc_wide), .acc_wdata(acc_wdata), .cnt_view(cnt_view),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .hi_load(hi_load), .hi_en(hi_en),
    .acc_rdata(acc_rdata), .acc_err(acc_err)
  );

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .hi_load(hi_load), .hi_en(hi_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cnt_view(cnt_view), .period_pulse(period_pulse), .match_b_pulse(match_b_pulse)
  );
endmodule

// File: tb/test_tmr_upcount.sv
module test_tmr_upcount;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // each entry: {period, compare B}
  localparam logic [NV-1:0][31:0] VEC = {
    {16'd4, 16'd9}, {16'd8, 16'd7}, {16'd1, 16'd0}, {16'd3, 16'd0}, {16'd5, 16'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, wr = 1'b0, wide = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        err, ovf, mb;
  logic [15:0] d;
  logic        e;
  int          nchk = 0, nbad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_upcount i_tmr_upcount (
    .clk(clk), .rst_n(rst_n), .acc_vld(vld), .acc_wr(wr), .acc_addr(addr),
    .acc_wide(wide), .acc_wdata(wdata), .acc_rdata(rdata), .acc_err(err),
    .period_pulse(ovf), .match_b_pulse(mb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_acc(input logic [7:0] a, input logic w, input logic [15:0] v);
    @(negedge clk);
    vld = 1'b1; wr = 1'b1; addr = a; wide = w; wdata = v;
    @(negedge clk);
    vld = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_acc(input logic [7:0] a, input logic w,
                        output logic [15:0] v, output logic ef);
    @(negedge clk);
    vld = 1'b1; wr = 1'b0; addr = a; wide = w;
    #1 v = rdata;
    @(negedge clk);
    vld = 1'b0;
    ef = err;
  endtask

  task automatic peek(input logic [7:0] a, input logic w, output logic [15:0] v);
    addr = a; wide = w;
    #1 v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(8'h84, 1'b1, d); chk(d == 16'h0, "R1 mode", d, 0);
    peek(8'hC4, 1'b1, d); chk(d == 16'h0, "R1 cmpA", d, 0);
    peek(8'hD4, 1'b1, d); chk(d == 16'h0, "R1 cmpB", d, 0);
    peek(8'hB5, 1'b0, d); chk(d == 16'h0, "R1 cmodeB", d, 0);
    peek(8'hA4, 1'b1, d); chk(d == 16'h0, "R1 count", d, 0);
    chk(!ovf && !mb && !err, "R1 outputs", {ovf, mb, err}, 0);

    // R2 mode layout
    wr_acc(8'h84, 1'b0, 16'h0013);
    peek(8'h84, 1'b0, d); chk(d == 16'h0013, "R2 low byte", d, 16'h13);
    wr_acc(8'h84, 1'b1, 16'h4051);
    peek(8'h84, 1'b1, d); chk(d == 16'h4051, "R2 wide mode", d, 16'h4051);
    peek(8'h85, 1'b0, d); chk(d == 16'h0040, "R2 high byte", d, 16'h40);

    // R3 reserved bits
    wr_acc(8'h84, 1'b0, 16'h0004);
    chk(err, "R3 low reserved err", err, 1);
    peek(8'h84, 1'b0, d); chk(d == 16'h0051, "R3 low kept", d, 16'h51);
    wr_acc(8'h85, 1'b0, 16'h0001);
    chk(err, "R3 high reserved err", err, 1);
    peek(8'h85, 1'b0, d); chk(d == 16'h0040, "R3 high kept", d, 16'h40);

    // R4 enable with load
    wr_acc(8'hC4, 1'b1, 16'd5);
    wr_acc(8'h85, 1'b0, 16'h00C0);
    chk(err, "R4 err", err, 1);
    repeat (3) @(negedge clk);
    peek(8'hA4, 1'b1, d); chk(d == 16'h0, "R4 not running", d, 0);
    peek(8'h85, 1'b0, d); chk(d == 16'h0040, "R4 mode kept", d, 16'h40);

    // R5 zero period
    wr_acc(8'hC4, 1'b1, 16'd0);
    wr_acc(8'h85, 1'b0, 16'h0080);
    chk(!err, "R5 legal", err, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      peek(8'hA4, 1'b1, d);
      chk(d == 16'h0 && !ovf, "R5 zero period idle", d, 0);
    end
    wr_acc(8'h85, 1'b0, 16'h0000);

    // R11 compare and compare-mode access
    wr_acc(8'hD4, 1'b0, 16'h77AB);
    peek(8'hD4, 1'b1, d); chk(d == 16'h00AB, "R11 byte zero-extend", d, 16'hAB);
    wr_acc(8'hB4, 1'b0, 16'h005A);
    peek(8'hB4, 1'b0, d); chk(d == 16'h005A, "R11 cmodeA", d, 16'h5A);
    wr_acc(8'hB5, 1'b1, 16'h1234);
    chk(err, "R11 wide cmodeB err", err, 1);
    peek(8'hB5, 1'b0, d); chk(d == 16'h0000, "R11 cmodeB kept", d, 0);

    // R12 illegal accesses
    wr_acc(8'hA4, 1'b1, 16'h1234);
    chk(err, "R12 counter write err", err, 1);
    peek(8'hA4, 1'b1, d); chk(d == 16'h0, "R12 counter kept", d, 0);
    rd_acc(8'h10, 1'b0, d, e);
    chk(d == 16'h0 && e, "R12 unmapped read", {d, e}, 1);
    wr_acc(8'h85, 1'b1, 16'h0080);
    chk(err, "R12 wide high err", err, 1);
    peek(8'hA4, 1'b1, d); chk(d == 16'h0, "R12 not started", d, 0);

    // R6 / R8 stimulus table
    for (int v = 0; v < NV; v++) begin
      int p, b;
      p = int'(VEC[v][31:16]);
      b = int'(VEC[v][15:0]);
      wr_acc(8'hC4, 1'b1, 16'(p));
      wr_acc(8'hD4, 1'b1, 16'(b));
      wr_acc(8'h85, 1'b0, 16'h0080);
      peek(8'hA4, 1'b1, d); chk(d == 16'h0, "R5 start at zero", d, 0);
      for (int k = 1; k <= 2 * p + 3; k++) begin
        @(negedge clk);
        peek(8'hA4, 1'b1, d);
        chk(int'(d) == k % p, "R6 count", d, k % p);
        chk(ovf == (k % p == 0), "R6 period pulse", ovf, k % p == 0);
        chk(mb == (k % p == b), "R8 match pulse", mb, k % p == b);
      end
      wr_acc(8'h85, 1'b0, 16'h0000);
    end

    // R7 compare A rewritten mid-run
    wr_acc(8'hD4, 1'b1, 16'd100);
    wr_acc(8'hC4, 1'b1, 16'd6);
    wr_acc(8'h85, 1'b0, 16'h0080);
    wr_acc(8'hC4, 1'b0, 16'h0003);
    for (int k = 3; k <= 13; k++) begin
      @(negedge clk);
      peek(8'hA4, 1'b1, d);
      chk(int'(d) == k % 6, "R7 period held", d, k % 6);
      chk(ovf == (k % 6 == 0), "R7 pulse", ovf, k % 6 == 0);
    end

    // R10 stop
    wr_acc(8'h85, 1'b0, 16'h0000);
    peek(8'hA4, 1'b1, d); chk(d == 16'h0, "R10 count cleared", d, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(!ovf && !mb, "R10 outputs low", {ovf, mb}, 0);
    end

    // R9 counter read widths
    wr_acc(8'hC4, 1'b1, 16'h0120);
    wr_acc(8'h85, 1'b0, 16'h0080);
    repeat (260) @(negedge clk);
    peek(8'hA4, 1'b1, d); chk(d == 16'd260, "R9 wide count", d, 260);
    peek(8'hA4, 1'b0, d); chk(d == 16'd4, "R9 byte count", d, 4);
    wr_acc(8'h85, 1'b0, 16'h0000);
    peek(8'hA4, 1'b1, d); chk(d == 16'h0, "R9 stopped reads zero", d, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule